// File: doc/BRIEF.md
# UART Transmit/Receive Byte Queues with Paired Access

This block holds the two byte queues of a 16550-class serial port: one that the host fills and the serializer drains (transmit), and one that the deserializer fills and the host drains (receive). The host side may move either one byte or two bytes per access, selected per access by a width input, so a DMA engine can transfer halfword beats. The queue capacity is either 16 or 64 bytes, chosen by a mode input.

A two-byte access that cannot be completed in full is refused outright. A refused receive read returns zeros and removes nothing. A refused transmit write stores nothing. Each refusal sets a sticky error bit that the status logic reads back. The block also drives the data-ready and transmit-empty indications and the fill level of each queue to the line-status logic. A single clear input empties both queues and drops both error bits. The capacity mode may only be changed together with that clear.

Top module: `uart_fifo_pair`

## Requirements
- R1: With `deep_mode`=0 each queue holds at most 16 bytes, and with `deep_mode`=1 at most 64. The fill level never exceeds the selected capacity.
- R2: A host write with `wide_acc`=0 appends `host_wdata[7:0]`. With `wide_acc`=1 it appends `host_wdata[7:0]` first and then `host_wdata[15:8]`. A `tx_pop` presents the oldest transmit byte on `tx_pop_data` in the cycle after the pop.
- R3: `rx_push` appends `rx_push_data`. A host read with `wide_acc`=0 returns the oldest byte on `host_rdata[7:0]` with `host_rdata[15:8]`=0. With `wide_acc`=1 it returns the older byte in `[7:0]` and the next byte in `[15:8]`. The data appears in the cycle after the read.
- R4: A host read when the receive queue is empty, or a two-byte read when exactly one byte is stored, removes no byte. It shows `host_rdata`=0 in the next cycle and sets `rx_err_stat[7]`. A read is judged against the level held before that cycle, even if `rx_push` is asserted in the same cycle.
- R5: A host write when the transmit queue is full, or a two-byte write with one free slot, is ignored entirely: the level and the queued bytes are unchanged. It sets `tx_err_stat[7]`.
- R6: The error bits are sticky. A pulse on `rx_stat_rd` or `tx_stat_rd` clears the matching bit in the next cycle. A new error in the same cycle as that pulse leaves the bit set. Bits 6:0 of both status bytes are always 0.
- R7: `rx_ready` is 1 exactly when the receive level is nonzero. `tx_empty` is 1 exactly when the transmit level is zero. Both follow a level change in the cycle after the access that caused it.
- R8: `fifo_clr` empties both queues and clears both error bits in the next cycle. Any access in the same cycle is dropped and raises no error.
- R9: Byte order is preserved when the storage pointer wraps, including a two-byte access whose bytes straddle the wrap.
- R10: After reset both levels are 0, both error bits are 0, `rx_ready`=0, `tx_empty`=1 and `host_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deep_mode | input | 1 | 0: 16-byte capacity, 1: 64-byte capacity |
| fifo_clr | input | 1 | Empty both queues and drop error bits |
| wide_acc | input | 1 | Host access width: 0 one byte, 1 two bytes |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wdata | input | 16 | Host write data, low byte queued first |
| host_rd | input | 1 | Host read strobe from the receive queue |
| rx_push | input | 1 | Deserializer pushes one byte |
| rx_push_data | input | 8 | Byte pushed by the deserializer |
| tx_pop | input | 1 | Serializer takes one byte |
| rx_stat_rd | input | 1 | Read of the receive error status (clears it) |
| tx_stat_rd | input | 1 | Read of the transmit error status (clears it) |
| host_rdata | output | 16 | Host read data, older byte in the low half |
| tx_pop_data | output | 8 | Byte taken by the serializer |
| rx_level | output | 7 | Receive queue fill level |
| tx_level | output | 7 | Transmit queue fill level |
| rx_ready | output | 1 | Receive queue holds at least one byte |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_err_stat | output | 8 | Receive status byte, bit 7 = underrun |
| tx_err_stat | output | 8 | Transmit status byte, bit 7 = overrun |

## Verification
A read or write pointer that drifts from the level counter shows up as out-of-order or stale bytes on `host_rdata` or `tx_pop_data` in the cycle after the next pop, so the bench checks every popped byte against its own model of queue order. A wrong lane select on a straddling two-byte access shows as swapped halves on the very next read. A level count that ignores a refused access shows at once on the level outputs and on `rx_ready` or `tx_empty`. It then shows again, later, as a missing or extra byte when the queue is drained.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  // Host access width encoding carried on wide_acc
  typedef enum logic {
    ACC_ONE = 1'b0,
    ACC_TWO = 1'b1
  } acc_width_e;

  // Number of bytes moved by an access of the given width
  function automatic int unsigned bytes_of(input logic two);
    return (two == ACC_TWO) ? 2 : 1;
  endfunction
endpackage

// File: rtl/fifo_lane_ram.sv
// One storage lane: simple dual-port, synchronous write and read,
// written so that a block RAM can be inferred.
module fifo_lane_ram #(
  parameter int ROWS = 32,
  parameter int W    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(ROWS)-1:0]  waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     re,
  input  logic [$clog2(ROWS)-1:0]  raddr,
  output logic [W-1:0]             q
);
  logic [W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dual_lane_fifo.sv
// Byte queue split across two interleaved lanes (even and odd positions),
// so one or two bytes can be pushed and popped per cycle.
module dual_lane_fifo
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH   = 64,   // power of two, largest capacity
  parameter int SHALLOW = 16,   // reduced capacity
  parameter int W       = 8,
  parameter int CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             deep,
  input  logic             push,
  input  logic             push_two,
  input  logic [2*W-1:0]   wdata,
  input  logic             pop,
  input  logic             pop_two,
  output logic [2*W-1:0]   rdata,
  output logic [CNT_W-1:0] level,
  output logic             push_fail,
  output logic             pop_fail
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int ROWS  = DEPTH / 2;
  localparam int RW    = PTR_W - 1;

  logic [PTR_W-1:0] wp, rp, wp_nx1, rp_nx1;
  logic [CNT_W-1:0] cap, push_n, pop_n;
  logic             push_ok, pop_ok;
  logic [1:0][W-1:0] lane_q;
  logic             sel_r, ok_r, two_r;
  logic [W-1:0]     lo_b, hi_b;

  assign cap    = deep ? CNT_W'(DEPTH) : CNT_W'(SHALLOW);
  assign push_n = CNT_W'(bytes_of(push_two));
  assign pop_n  = CNT_W'(bytes_of(pop_two));
  assign wp_nx1 = wp + PTR_W'(1);
  assign rp_nx1 = rp + PTR_W'(1);

  // Judged against the level held before this cycle
  assign push_ok   = push && !clr && ((level + push_n) <= cap);
  assign pop_ok    = pop  && !clr && (level >= pop_n);
  assign push_fail = push && !clr && !push_ok;
  assign pop_fail  = pop  && !clr && !pop_ok;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic          own_w, own_r, we;
    logic [RW-1:0] waddr, raddr;
    logic [W-1:0]  wbyte;

    // The lane that holds the pointer's position takes the earlier byte
    assign own_w = (wp[0] == 1'(l));
    assign own_r = (rp[0] == 1'(l));
    assign we    = push_ok && (own_w || push_two);
    assign waddr = own_w ? wp[PTR_W-1:1] : wp_nx1[PTR_W-1:1];
    assign wbyte = own_w ? wdata[W-1:0] : wdata[2*W-1:W];
    assign raddr = own_r ? rp[PTR_W-1:1] : rp_nx1[PTR_W-1:1];

    fifo_lane_ram #(.ROWS(ROWS), .W(W)) u_ram (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wbyte),
      .re    (pop_ok),
      .raddr (raddr),
      .q     (lane_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp + PTR_W'(push_n);
      if (pop_ok)  rp <= rp + PTR_W'(pop_n);
      level <= level + (push_ok ? push_n : '0) - (pop_ok ? pop_n : '0);
    end
  end

  // Remembers how to assemble the lane outputs for the last pop attempt
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ok_r  <= 1'b0;
      two_r <= 1'b0;
      sel_r <= 1'b0;
    end else if (pop) begin
      ok_r  <= pop_ok;
      two_r <= pop_two;
      sel_r <= rp[0];
    end
  end

  assign lo_b  = sel_r ? lane_q[1] : lane_q[0];
  assign hi_b  = sel_r ? lane_q[0] : lane_q[1];
  assign rdata = !ok_r ? '0 : (two_r ? {hi_b, lo_b} : {W'(0), lo_b});

  assert_level_within_cap_R1: assert property (@(posedge clk) disable iff (rst)
    level <= cap);

  assert_refused_push_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (push_fail && !pop) |=> $stable(level));

  assert_refused_pop_keeps_level_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_fail && !push) |=> ($stable(level) && rdata == '0));
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEEP_DEPTH    = 64,
  parameter int SHALLOW_DEPTH = 16,
  parameter int BYTE_W        = 8,
  parameter int LVL_W         = $clog2(DEEP_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              deep_mode,
  input  logic              fifo_clr,
  input  logic              wide_acc,
  input  logic              host_wr,
  input  logic [2*BYTE_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_push_data,
  input  logic              tx_pop,
  input  logic              rx_stat_rd,
  input  logic              tx_stat_rd,
  output logic [2*BYTE_W-1:0] host_rdata,
  output logic [BYTE_W-1:0] tx_pop_data,
  output logic [LVL_W-1:0]  rx_level,
  output logic [LVL_W-1:0]  tx_level,
  output logic              rx_ready,
  output logic              tx_empty,
  output logic [7:0]        rx_err_stat,
  output logic [7:0]        tx_err_stat
);
  logic [2*BYTE_W-1:0] tx_rd;
  logic [BYTE_W-1:0]   tx_hi_unused;
  logic tx_over, rx_under, rx_push_fail_unused, tx_pop_fail_unused;
  logic rx_flag, tx_flag;

  dual_lane_fifo #(.DEPTH(DEEP_DEPTH), .SHALLOW(SHALLOW_DEPTH), .W(BYTE_W), .CNT_W(LVL_W)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .clr       (fifo_clr),
    .deep      (deep_mode),
    .push      (host_wr),
    .push_two  (wide_acc),
    .wdata     (host_wdata),
    .pop       (tx_pop),
    .pop_two   (ACC_ONE),
    .rdata     (tx_rd),
    .level     (tx_level),
    .push_fail (tx_over),
    .pop_fail  (tx_pop_fail_unused)
  );

  dual_lane_fifo #(.DEPTH(DEEP_DEPTH), .SHALLOW(SHALLOW_DEPTH), .W(BYTE_W), .CNT_W(LVL_W)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .clr       (fifo_clr),
    .deep      (deep_mode),
    .push      (rx_push),
    .push_two  (ACC_ONE),
    .wdata     ({BYTE_W'(0), rx_push_data}),
    .pop       (host_rd),
    .pop_two   (wide_acc),
    .rdata     (host_rdata),
    .level     (rx_level),
    .push_fail (rx_push_fail_unused),
    .pop_fail  (rx_under)
  );

  assign tx_pop_data  = tx_rd[BYTE_W-1:0];
  assign tx_hi_unused = tx_rd[2*BYTE_W-1:BYTE_W];

  // Sticky error bits: a new error wins over a clearing status read
  always_ff @(posedge clk) begin
    if (rst || fifo_clr) begin
      rx_flag <= 1'b0;
      tx_flag <= 1'b0;
    end else begin
      if (rx_under)        rx_flag <= 1'b1;
      else if (rx_stat_rd) rx_flag <= 1'b0;
      if (tx_over)         tx_flag <= 1'b1;
      else if (tx_stat_rd) tx_flag <= 1'b0;
    end
  end

  assign rx_err_stat = {rx_flag, 7'b0};
  assign tx_err_stat = {tx_flag, 7'b0};
  assign rx_ready    = (rx_level != '0);
  assign tx_empty    = (tx_level == '0);

  logic [LVL_W:0] cap_chk;
  assign cap_chk = deep_mode ? (LVL_W+1)'(DEEP_DEPTH) : (LVL_W+1)'(SHALLOW_DEPTH);

  assert_underrun_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !fifo_clr && (int'(rx_level) < (wide_acc ? 2 : 1)))
      |=> (rx_err_stat[7] && host_rdata == '0));

  assert_overrun_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !fifo_clr && (int'(tx_level) + (wide_acc ? 2 : 1) > int'(cap_chk)))
      |=> tx_err_stat[7]);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (rx_level == '0 && tx_level == '0 && !rx_err_stat[7] && !tx_err_stat[7]));

  assert_stat_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_stat_rd && !fifo_clr && !(host_wr && int'(tx_level) + (wide_acc ? 2 : 1) > int'(cap_chk)))
      |=> !tx_err_stat[7]);
endmodule

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic deep_mode = 1'b0, fifo_clr = 1'b0, wide_acc = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, rx_push = 1'b0, tx_pop = 1'b0;
  logic rx_stat_rd = 1'b0, tx_stat_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  rx_push_data = '0;
  logic [15:0] host_rdata;
  logic [7:0]  tx_pop_data, rx_err_stat, tx_err_stat;
  logic [6:0]  rx_level, tx_level;
  logic        rx_ready, tx_empty;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  uart_fifo_pair u_uart_fifo_pair (
    .clk, .rst, .deep_mode, .fifo_clr, .wide_acc, .host_wr, .host_wdata,
    .host_rd, .rx_push, .rx_push_data, .tx_pop, .rx_stat_rd, .tx_stat_rd,
    .host_rdata, .tx_pop_data, .rx_level, .tx_level, .rx_ready, .tx_empty,
    .rx_err_stat, .tx_err_stat
  );

  // op: 0 host write, 1 serial tx pop, 2 serial rx push, 3 host read
  // {op[2], wide, din[16], exp[16], tx_lvl[7], rx_lvl[7], tx_err, rx_err}
  localparam int NV = 17;
  localparam logic [50:0] VECS [NV] = '{
    {2'd0, 1'b0, 16'h00A1, 16'h0000, 7'd1, 7'd0, 1'b0, 1'b0},
    {2'd0, 1'b1, 16'hC3B2, 16'h0000, 7'd3, 7'd0, 1'b0, 1'b0},
    {2'd1, 1'b0, 16'h0000, 16'h00A1, 7'd2, 7'd0, 1'b0, 1'b0},
    {2'd1, 1'b0, 16'h0000, 16'h00B2, 7'd1, 7'd0, 1'b0, 1'b0},
    {2'd1, 1'b0, 16'h0000, 16'h00C3, 7'd0, 7'd0, 1'b0, 1'b0},
    {2'd2, 1'b0, 16'h0011, 16'h0000, 7'd0, 7'd1, 1'b0, 1'b0},
    {2'd2, 1'b0, 16'h0022, 16'h0000, 7'd0, 7'd2, 1'b0, 1'b0},
    {2'd2, 1'b0, 16'h0033, 16'h0000, 7'd0, 7'd3, 1'b0, 1'b0},
    {2'd3, 1'b1, 16'h0000, 16'h2211, 7'd0, 7'd1, 1'b0, 1'b0},
    {2'd3, 1'b1, 16'h0000, 16'h0000, 7'd0, 7'd1, 1'b0, 1'b1},
    {2'd3, 1'b0, 16'h0000, 16'h0033, 7'd0, 7'd0, 1'b0, 1'b1},
    {2'd3, 1'b0, 16'h0000, 16'h0000, 7'd0, 7'd0, 1'b0, 1'b1},
    {2'd0, 1'b1, 16'h5544, 16'h0000, 7'd2, 7'd0, 1'b0, 1'b1},
    {2'd1, 1'b0, 16'h0000, 16'h0044, 7'd1, 7'd0, 1'b0, 1'b1},
    {2'd0, 1'b0, 16'h0066, 16'h0000, 7'd2, 7'd0, 1'b0, 1'b1},
    {2'd1, 1'b0, 16'h0000, 16'h0055, 7'd1, 7'd0, 1'b0, 1'b1},
    {2'd1, 1'b0, 16'h0000, 16'h0066, 7'd0, 7'd0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic wide, input logic [15:0] din);
    @(negedge clk);
    wide_acc = wide;
    case (op)
      2'd0: begin host_wr = 1'b1; host_wdata = din; end
      2'd1: tx_pop = 1'b1;
      2'd2: begin rx_push = 1'b1; rx_push_data = din[7:0]; end
      default: host_rd = 1'b1;
    endcase
    @(negedge clk);
    host_wr = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; host_rd = 1'b0;
  endtask

  task automatic clear_all(input logic deep);
    @(negedge clk);
    fifo_clr = 1'b1; deep_mode = deep;
    @(negedge clk);
    fifo_clr = 1'b0;
  endtask

  task automatic stat_read(input logic rx, input logic tx);
    @(negedge clk);
    rx_stat_rd = rx; tx_stat_rd = tx;
    @(negedge clk);
    rx_stat_rd = 1'b0; tx_stat_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 rx_level", 32'(rx_level), 0);
    check("R10 tx_level", 32'(tx_level), 0);
    check("R10 rx_ready/tx_empty", {30'b0, rx_ready, tx_empty}, 32'b01);
    check("R10 host_rdata", 32'(host_rdata), 0);
    check("R10 err status", {16'b0, rx_err_stat, tx_err_stat}, 0);

    // Table walk: R2 R3 R4 R7 order and levels in 16-byte mode
    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VECS[i];
      access(v[50:49], v[48], v[47:32]);
      if (v[50:49] == 2'd1) check("R2 tx pop byte", 32'(tx_pop_data), 32'(v[23:16]));
      if (v[50:49] == 2'd3) check("R3/R4 host read data", 32'(host_rdata), 32'(v[31:16]));
      check("R7 levels", {18'b0, tx_level, rx_level}, {18'b0, v[15:2]});
      check("R4/R5 err bits", {30'b0, tx_err_stat[7], rx_err_stat[7]}, {30'b0, v[1:0]});
      check("R7 ready/empty", {30'b0, rx_ready, tx_empty}, {30'b0, v[8:2] != 0, v[15:9] == 0});
    end

    // R6 read clears rx flag; low bits stay zero
    check("R6 low bits zero", 32'(rx_err_stat[6:0]), 0);
    stat_read(1'b1, 1'b0);
    check("R6 rx flag cleared", 32'(rx_err_stat), 0);

    // R6 new error in the same cycle as the status read keeps the bit set
    @(negedge clk);
    host_rd = 1'b1; wide_acc = 1'b0; rx_stat_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; rx_stat_rd = 1'b0;
    check("R6 set wins over read", 32'(rx_err_stat), 32'h80);

    // R4 read with simultaneous push at level 0 is refused, push lands
    stat_read(1'b1, 1'b0);
    @(negedge clk);
    host_rd = 1'b1; rx_push = 1'b1; rx_push_data = 8'h77;
    @(negedge clk);
    host_rd = 1'b0; rx_push = 1'b0;
    check("R4 refused read data", 32'(host_rdata), 0);
    check("R4 refused read flag", 32'(rx_err_stat[7]), 1);
    check("R4 push still lands", 32'(rx_level), 1);
    access(2'd3, 1'b0, 16'h0);
    check("R3 pushed byte readable", 32'(host_rdata), 32'h77);

    // R1 R5 16-byte transmit capacity and ignored writes
    clear_all(1'b0);
    check("R8 flags cleared", {16'b0, rx_err_stat, tx_err_stat}, 0);
    for (int k = 0; k < 15; k++) access(2'd0, 1'b0, 16'(k + 8'h10));
    access(2'd0, 1'b1, 16'hEEDD);
    check("R5 wide write one slot free level", 32'(tx_level), 15);
    check("R5 wide write one slot free flag", 32'(tx_err_stat), 32'h80);
    stat_read(1'b0, 1'b1);
    check("R6 tx flag cleared", 32'(tx_err_stat), 0);
    access(2'd0, 1'b0, 16'h0050);
    check("R1 full at 16", 32'(tx_level), 16);
    access(2'd0, 1'b0, 16'h0099);
    check("R5 full write level", 32'(tx_level), 16);
    check("R5 full write flag", 32'(tx_err_stat[7]), 1);
    for (int k = 0; k < 16; k++) begin
      access(2'd1, 1'b0, 16'h0);
      check("R2/R5 drain order", 32'(tx_pop_data), (k < 15) ? 32'(k + 8'h10) : 32'h50);
    end
    check("R7 tx_empty after drain", 32'(tx_empty), 1);

    // R8 clear drops a same-cycle write and any error
    @(negedge clk);
    fifo_clr = 1'b1; host_wr = 1'b1; host_wdata = 16'h1234; wide_acc = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0; host_wr = 1'b0;
    check("R8 level after clear", 32'(tx_level), 0);
    check("R8 flag after clear", 32'(tx_err_stat), 0);

    // R1 64-byte mode with paired writes, then drain in order
    clear_all(1'b1);
    for (int k = 0; k < 32; k++) access(2'd0, 1'b1, {8'(2*k + 1), 8'(2*k)});
    check("R1 full at 64", 32'(tx_level), 64);
    access(2'd0, 1'b0, 16'h00FF);
    check("R5 deep full write level", 32'(tx_level), 64);
    check("R5 deep full write flag", 32'(tx_err_stat[7]), 1);
    for (int k = 0; k < 64; k++) begin
      access(2'd1, 1'b0, 16'h0);
      check("R2 deep drain order", 32'(tx_pop_data), 32'(k));
    end

    // R9 paired read straddling the pointer wrap
    for (int k = 0; k < 63; k++) access(2'd2, 1'b0, 16'(k));
    for (int k = 0; k < 63; k++) begin
      access(2'd3, 1'b0, 16'h0);
      check("R3 single reads", 32'(host_rdata), 32'(k));
    end
    for (int k = 0; k < 4; k++) access(2'd2, 1'b0, 16'(8'hA0 + k));
    access(2'd3, 1'b1, 16'h0);
    check("R9 straddling read", 32'(host_rdata), 32'hA1A0);
    access(2'd3, 1'b1, 16'h0);
    check("R9 read after wrap", 32'(host_rdata), 32'hA3A2);
    check("R7 rx_ready after drain", 32'(rx_ready), 0);

    finish_run();
  end
endmodule